// File: doc/BRIEF.md
# Multi-Ratio Processor Clock Generator

This block takes one oscillator input and produces three clocks from it. The processor clock has a one-third duty cycle. A companion clock runs at the same rate with a half duty cycle, and both fall on the same oscillator transition. A peripheral clock runs at one sixth of the oscillator rate with a half duty cycle. A fast/slow select sets the two main clocks to either one third or 1/768 of the oscillator rate. The change is applied only when the processor clock falls, so no clipped pulse reaches the processor.

A clock-sync input stops all three outputs high. It lets several generators line up on a common external event. The sync input must already be synchronous to the oscillator. When it is released, all outputs fall together on the next oscillator rising edge. A stop command freezes the peripheral clock at its present level while the main clocks keep running. A start command or a reset lets it run again.

Top module: `clkgen_tri`

## Requirements
- R1: While `rst_n` is low (active-low, asynchronous), all three outputs are low. After release, with `slow` and `csync` low, `clk_cpu` is high after the second oscillator rising edge and falls at the third.
- R2: In fast mode (`slow` = 0), `clk_cpu` repeats every 3 oscillator periods and is high for 1 period of them.
- R3: In fast mode, `clk_half` is high for 1.5 and low for 1.5 oscillator periods, using both oscillator edges. Each fall of `clk_cpu` coincides with a fall of `clk_half`, and `clk_cpu` is high only while `clk_half` is high.
- R4: In slow mode (`slow` = 1), `clk_cpu` is high for 256 and low for 512 oscillator periods, and `clk_half` is high and low for 384 periods each.
- R5: `clk_per` is high for 3 and low for 3 oscillator periods in both modes. In fast mode, every fall of `clk_per` coincides with a fall of `clk_cpu`.
- R6: A change of `slow` takes effect only at the next fall of `clk_cpu`. A high phase that is already under way completes at its full length, and no high or low phase is shorter than its fast-mode length.
- R7: While `csync` (active high) is high, all three outputs are high. After `csync` is released, they stay high until the next oscillator rising edge and then fall together. This holds in both modes.
- R8: A `stop` pulse (active high, sampled on the oscillator rising edge) freezes `clk_per` at its current level while `clk_cpu` keeps running. A `start` pulse resumes it. When both are high in the same cycle, `start` wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc | input | 1 | Oscillator input, the base frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow | input | 1 | 1 selects divide-by-768, 0 selects divide-by-3 for the main clocks |
| stop | input | 1 | Freezes the peripheral clock at its current level |
| start | input | 1 | Releases a frozen peripheral clock; wins over stop |
| csync | input | 1 | Holds all clocks high while active; already synchronous to osc |
| clk_cpu | output | 1 | One-third duty-cycle processor clock |
| clk_half | output | 1 | Half duty-cycle clock at the processor-clock rate |
| clk_per | output | 1 | Half duty-cycle peripheral clock at osc/6 |

## Verification
A monitor samples every half oscillator period and measures the high and low run lengths of each output, as well as edge coincidence between outputs. The main clocks are measured in steady fast mode and steady slow mode. Comparing the two shows that the ratio switch changes only the main clocks while the peripheral clock keeps its own run lengths. A slow-to-fast switch is issued in the middle of a slow high phase: a full 512-half-period phase followed by clean fast phases separates a deferred switch from an immediate one. The sync hold is released once in each mode, and stop, start and a simultaneous stop/start are applied to show which command governs the frozen state.

// File: rtl/clkgen_tri.sv
module clkgen_tri #(
  parameter int SLOW_DIV = 768,
  parameter int PER_DIV  = 6
) (
  input  logic osc,
  input  logic rst_n,
  input  logic slow,
  input  logic stop,
  input  logic start,
  input  logic csync,
  output logic clk_cpu,
  output logic clk_half,
  output logic clk_per
);
  localparam int CW = $clog2(SLOW_DIV);
  localparam int PW = $clog2(PER_DIV);
  localparam logic [CW-1:0] S_LAST = CW'(SLOW_DIV - 1);
  localparam logic [CW-1:0] S_CPU  = CW'(SLOW_DIV - SLOW_DIV / 3);
  localparam logic [CW-1:0] S_HALF = CW'(SLOW_DIV / 2);
  localparam logic [CW-1:0] F_LAST = CW'(2);
  localparam logic [CW-1:0] F_MID  = CW'(1);
  localparam logic [PW-1:0] P_LAST = PW'(PER_DIV - 1);
  localparam logic [PW-1:0] P_HI   = PW'(PER_DIV / 2);

  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic          mode_slow;
  logic          frozen;
  logic          mid;

  wire [CW-1:0] last = mode_slow ? S_LAST : F_LAST;
  wire          wrap = (cnt == last);

  // main divider; ratio is latched only on wrap (falling edge of clk_cpu)
  always_ff @(posedge osc or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      mode_slow <= 1'b0;
    end else if (csync) begin
      cnt       <= slow ? S_LAST : F_LAST;
      mode_slow <= slow;
    end else if (wrap) begin
      cnt       <= '0;
      mode_slow <= slow;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // half-period extension for the 50% clock at divide-by-3
  always_ff @(negedge osc or negedge rst_n) begin
    if (!rst_n) mid <= 1'b0;
    else        mid <= !mode_slow && (cnt == F_MID) && !csync;
  end

  always_ff @(posedge osc or negedge rst_n) begin
    if (!rst_n)     frozen <= 1'b0;
    else if (start) frozen <= 1'b0;
    else if (stop)  frozen <= 1'b1;
  end

  always_ff @(posedge osc or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (csync)   pcnt <= P_LAST;
    else if (!frozen) pcnt <= (pcnt == P_LAST) ? '0 : pcnt + 1'b1;
  end

  assign clk_cpu  = csync | (mode_slow ? (cnt >= S_CPU)  : (cnt == F_LAST));
  assign clk_half = csync | (mode_slow ? (cnt >= S_HALF) : ((cnt == F_LAST) | mid));
  assign clk_per  = csync | (pcnt >= P_HI);
endmodule

// File: rtl/clkgen_tri_chk.sv
module clkgen_tri_chk (
  input logic osc,
  input logic rst_n,
  input logic stop,
  input logic start,
  input logic csync,
  input logic clk_cpu,
  input logic clk_half,
  input logic clk_per
);
  p_cpu_within_half_r3: assert property (@(posedge osc) disable iff (!rst_n)
    clk_cpu |-> clk_half);

  p_falls_aligned_r3: assert property (@(posedge osc) disable iff (!rst_n)
    $fell(clk_cpu) |-> !clk_half);

  p_sync_release_high_r7: assert property (@(posedge osc) disable iff (!rst_n)
    $fell(csync) |-> (clk_cpu && clk_half && clk_per));

  p_per_frozen_r8: assert property (@(posedge osc) disable iff (!rst_n)
    ($past(stop) && !$past(start) && !start && !csync) |=> $stable(clk_per));
endmodule

bind clkgen_tri clkgen_tri_chk u_chk (
  .osc(osc), .rst_n(rst_n), .stop(stop), .start(start), .csync(csync),
  .clk_cpu(clk_cpu), .clk_half(clk_half), .clk_per(clk_per)
);

// File: tb/sim_clkgen_tri.sv
`timescale 1ns/1ps
module sim_clkgen_tri;
  logic osc = 1'b0, rst_n = 1'b0, slow = 1'b0, stop = 1'b0, start = 1'b0, csync = 1'b0;
  logic clk_cpu, clk_half, clk_per;
  int total = 0, fails = 0;

  clkgen_tri u0 (.osc(osc), .rst_n(rst_n), .slow(slow), .stop(stop), .start(start),
                 .csync(csync), .clk_cpu(clk_cpu), .clk_half(clk_half), .clk_per(clk_per));

  always #5 osc = ~osc;

  // half-period monitor: index 0 cpu, 1 half, 2 per
  int hidx = 0, sr = 0;
  logic prv [3];
  int st [3], hi_len [3], lo_len [3], min_hi [3], min_lo [3], lowcnt [3], toggles [3];
  int mis_fc = 0, mis_pc = 0;

  task automatic clear_stats();
    sr = hidx;
    mis_fc = 0; mis_pc = 0;
    for (int i = 0; i < 3; i++) begin
      hi_len[i] = -1; lo_len[i] = -1; min_hi[i] = 99999; min_lo[i] = 99999;
      lowcnt[i] = 0; toggles[i] = 0;
    end
  endtask

  task automatic sample();
    logic cur [3];
    logic fell [3];
    cur[0] = clk_cpu; cur[1] = clk_half; cur[2] = clk_per;
    for (int i = 0; i < 3; i++) begin
      fell[i] = 1'b0;
      if (!cur[i]) lowcnt[i]++;
      if (cur[i] !== prv[i]) begin
        if (st[i] >= sr) begin
          if (prv[i]) begin
            hi_len[i] = hidx - st[i];
            if (hi_len[i] < min_hi[i]) min_hi[i] = hi_len[i];
          end else begin
            lo_len[i] = hidx - st[i];
            if (lo_len[i] < min_lo[i]) min_lo[i] = lo_len[i];
          end
        end
        fell[i] = prv[i] && !cur[i];
        toggles[i]++;
        st[i] = hidx;
        prv[i] = cur[i];
      end
    end
    if (fell[0] && !fell[1]) mis_fc++;
    if (fell[2] && !fell[0]) mis_pc++;
    hidx++;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin prv[i] = 1'b0; st[i] = 0; end
    clear_stats();
    forever begin
      @(posedge osc); #2; sample();
      @(negedge osc); #2; sample();
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(posedge osc);
    @(negedge osc); #1;
  endtask

  task automatic t_reset();
    cycles(4);
    chk("R1 cpu low in reset", clk_cpu, 0);
    chk("R1 half low in reset", clk_half, 0);
    chk("R1 per low in reset", clk_per, 0);
    rst_n = 1'b1;
    @(posedge osc); @(posedge osc); #2;
    chk("R1 cpu high after 2nd edge", clk_cpu, 1);
    @(posedge osc); #2;
    chk("R1 cpu falls at 3rd edge", clk_cpu, 0);
    @(negedge osc); #1;
  endtask

  task automatic t_fast();
    clear_stats();
    cycles(40);
    chk("R2 cpu high halves", hi_len[0], 2);
    chk("R2 cpu low halves", lo_len[0], 4);
    chk("R3 half high halves", hi_len[1], 3);
    chk("R3 half low halves", lo_len[1], 3);
    chk("R3 cpu falls without half fall", mis_fc, 0);
    chk("R5 per high halves fast", hi_len[2], 6);
    chk("R5 per low halves fast", lo_len[2], 6);
    chk("R5 per falls off cpu falls", mis_pc, 0);
  endtask

  task automatic t_slow();
    slow = 1'b1;
    cycles(800);
    clear_stats();
    cycles(2400);
    chk("R4 cpu high halves", hi_len[0], 512);
    chk("R4 cpu low halves", lo_len[0], 1024);
    chk("R4 half high halves", hi_len[1], 768);
    chk("R4 half low halves", lo_len[1], 768);
    chk("R5 per high halves slow", hi_len[2], 6);
    chk("R5 per low halves slow", lo_len[2], 6);
  endtask

  task automatic t_switch();
    @(negedge clk_cpu); #3;
    clear_stats();
    @(posedge clk_cpu);
    @(negedge osc); #1;
    slow = 1'b0;
    @(negedge clk_cpu); #3;
    chk("R6 slow high phase kept full", hi_len[0], 512);
    cycles(30);
    chk("R6 fast cpu high after switch", hi_len[0], 2);
    chk("R6 fast cpu low after switch", lo_len[0], 4);
    chk("R6 no short high phase", min_hi[0], 2);
    chk("R6 no short low phase", min_lo[0], 4);
  endtask

  task automatic sync_once(string tag, int hold);
    csync = 1'b1;
    clear_stats();
    cycles(hold);
    chk({tag, " low samples during sync"}, lowcnt[0] + lowcnt[1] + lowcnt[2], 0);
    csync = 1'b0;
    #1;
    chk({tag, " all high after release"}, int'({clk_cpu, clk_half, clk_per}), 7);
    @(posedge osc); #2;
    chk({tag, " all fall at next edge"}, int'({clk_cpu, clk_half, clk_per}), 0);
    @(negedge osc); #1;
  endtask

  task automatic t_sync();
    sync_once("R7 fast", 20);
    slow = 1'b1;
    cycles(10);
    sync_once("R7 slow", 12);
    slow = 1'b0;
    csync = 1'b1;
    cycles(1);
    csync = 1'b0;
    cycles(20);
  endtask

  task automatic t_stop();
    stop = 1'b1; cycles(1); stop = 1'b0;
    cycles(2);
    clear_stats();
    cycles(60);
    chk("R8 per frozen after stop", toggles[2], 0);
    chk("R8 cpu still running", int'(toggles[0] > 10), 1);
    start = 1'b1; cycles(1); start = 1'b0;
    clear_stats();
    cycles(30);
    chk("R8 per high halves after start", hi_len[2], 6);
    chk("R8 per low halves after start", lo_len[2], 6);
    stop = 1'b1; start = 1'b1; cycles(1); stop = 1'b0; start = 1'b0;
    clear_stats();
    cycles(30);
    chk("R8 start wins over stop", int'(toggles[2] > 4), 1);
  endtask

  initial begin
    t_reset();
    t_fast();
    t_slow();
    t_switch();
    t_sync();
    t_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    #1000000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule